// File: doc/BRIEF.md
# Full-Bridge Gate Enable Sequencer

This block turns the two logic-level drive requests of one full bridge into four gate enables: a high-side and a low-side switch for leg A and the same pair for leg B. Each leg follows its own request bit. A 1 asks for the high-side switch and a 0 asks for the low-side switch. The four combinations therefore give a braking state with both low sides on, positive polarity, negative polarity, and a state with both high sides on that applications do not use.

Every change on a leg passes through an interval in which both of its switches are off. This interval lasts a set number of system-clock cycles and keeps the two switches of a leg from conducting at the same moment. Once a switch has turned on, it stays on for a minimum number of cycles, so a very short request cannot reach the power stage as a sliver. Three controls override the data inputs and turn every switch off: an active-low tri-state control, an active-low power-down control and an active-high fault input. All of these pins are plain level signals. The block has no streaming interface and no back-pressure.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, all four gate enables are 0.
- R2: If `tri_en_n` is 0 at a rising clock edge, all four gate enables are 0 after that edge, whatever the data inputs are.
- R3: If `pwr_up_n` is 0 at a rising clock edge, all four gate enables are 0 after that edge.
- R4: If `fault` is 1 at a rising clock edge, all four gate enables are 0 after that edge. This overrides every other input.
- R5: With the controls enabled and the inputs held steady, a leg whose request bit is 0 drives only its low-side enable, and a leg whose request bit is 1 drives only its high-side enable. So 00 gives lo_a and lo_b, 10 gives hi_a and lo_b, 01 gives lo_a and hi_b, and 11 gives hi_a and hi_b.
- R6: Before either enable of a leg turns on, both enables of that leg have been 0 for at least `DEAD_CYC` clock cycles. This also applies after reset and after a forced turn-off.
- R7: The high-side and low-side enables of one leg are never 1 in the same cycle.
- R8: A gate enable that has turned on stays on for at least `MIN_ON_CYC` cycles, unless R2, R3 or R4 forces it off.
- R9: The block adds no extra delay. A leg that has been off for `DEAD_CYC` cycles turns on at the next edge that finds a request for it. An enable that has been on for `MIN_ON_CYC` cycles turns off at the next edge that finds a different request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_a | input | 1 | Leg A request: 1 asks for the high side, 0 for the low side |
| req_b | input | 1 | Leg B request: 1 asks for the high side, 0 for the low side |
| tri_en_n | input | 1 | Active-low tri-state control; 0 turns all switches off |
| pwr_up_n | input | 1 | Active-low power-down control; 0 turns all switches off |
| fault | input | 1 | Fault input; 1 turns all switches off |
| hi_a | output | 1 | Leg A high-side gate enable |
| lo_a | output | 1 | Leg A low-side gate enable |
| hi_b | output | 1 | Leg B high-side gate enable |
| lo_b | output | 1 | Leg B low-side gate enable |

## Verification
The enables come straight from each leg's state register, so a wrong leg state shows at the ports in the same cycle it is taken. A miscounted dead-time or minimum-on counter shows up as an edge that arrives one or more cycles early or late, at the first transition after the fault. The bench compares all four enables on every cycle with a cycle-accurate reference model driven by random requests and controls. This catches such an error at its first edge. Directed sequences measure the dead gap and the stretched pulse directly in cycles.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_state_e;
endpackage

// File: rtl/bgc_gate_enable.sv
module bgc_gate_enable (
  input  logic tri_en_n,
  input  logic pwr_up_n,
  input  logic fault,
  output logic drive_ok
);
  // Any one of the three controls is enough to keep every switch off.
  always_comb drive_ok = tri_en_n & pwr_up_n & ~fault;
endmodule

// File: rtl/bgc_leg.sv
module bgc_leg #(
  parameter int DEAD_CYC   = 3,
  parameter int MIN_ON_CYC = 6,
  parameter int CNT_W      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_ok,
  input  logic req,
  output logic hi_en,
  output logic lo_en
);
  import bgc_pkg::*;

  localparam logic [CNT_W-1:0] DEAD_LIM = CNT_W'(DEAD_CYC - 1);
  localparam logic [CNT_W-1:0] MIN_LIM  = CNT_W'(MIN_ON_CYC - 1);

  leg_state_e st_q, st_d, want;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!drive_ok)
      want = LEG_OFF;
    else if (req)
      want = LEG_HI;
    else
      want = LEG_LO;
  end

  // One counter per leg: it counts off time in LEG_OFF and on time otherwise.
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (st_q == LEG_OFF) begin
      if (want != LEG_OFF && cnt_q >= DEAD_LIM) begin
        st_d  = want;
        cnt_d = '0;
      end else if (cnt_q < DEAD_LIM) begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (!drive_ok) begin
        st_d  = LEG_OFF;
        cnt_d = '0;
      end else if (want != st_q && cnt_q >= MIN_LIM) begin
        st_d  = LEG_OFF;
        cnt_d = '0;
      end else if (cnt_q < MIN_LIM) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LEG_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign hi_en = (st_q == LEG_HI);
  assign lo_en = (st_q == LEG_LO);
endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl #(
  parameter int DEAD_CYC   = 3,
  parameter int MIN_ON_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic req_b,
  input  logic tri_en_n,
  input  logic pwr_up_n,
  input  logic fault,
  output logic hi_a,
  output logic lo_a,
  output logic hi_b,
  output logic lo_b
);
  localparam int NUM_LEGS = 2;
  localparam int CNT_MAX  = (DEAD_CYC > MIN_ON_CYC) ? DEAD_CYC : MIN_ON_CYC;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  logic                drive_ok;
  logic [NUM_LEGS-1:0] req_v, hi_v, lo_v;

  assign req_v = {req_b, req_a};

  bgc_gate_enable u_en (
    .tri_en_n (tri_en_n),
    .pwr_up_n (pwr_up_n),
    .fault    (fault),
    .drive_ok (drive_ok)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    bgc_leg #(
      .DEAD_CYC   (DEAD_CYC),
      .MIN_ON_CYC (MIN_ON_CYC),
      .CNT_W      (CNT_W)
    ) u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .drive_ok (drive_ok),
      .req      (req_v[g]),
      .hi_en    (hi_v[g]),
      .lo_en    (lo_v[g])
    );
  end

  assign hi_a = hi_v[0];
  assign lo_a = lo_v[0];
  assign hi_b = hi_v[1];
  assign lo_b = lo_v[1];
endmodule

// File: rtl/bgc_checker.sv
module bgc_checker #(
  parameter int DEAD_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic tri_en_n,
  input logic pwr_up_n,
  input logic fault,
  input logic hi_a,
  input logic lo_a,
  input logic hi_b,
  input logic lo_b
);
  localparam int OW = $clog2(DEAD_CYC + 1);
  localparam logic [OW-1:0] OSAT = OW'(DEAD_CYC);

  logic [OW-1:0] off_run_a, off_run_b;
  logic all_off;
  assign all_off = !hi_a && !lo_a && !hi_b && !lo_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run_a <= '0;
      off_run_b <= '0;
    end else begin
      if (hi_a || lo_a) off_run_a <= '0;
      else if (off_run_a < OSAT) off_run_a <= off_run_a + 1'b1;
      if (hi_b || lo_b) off_run_b <= '0;
      else if (off_run_b < OSAT) off_run_b <= off_run_b + 1'b1;
    end
  end

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_a && lo_a) && !(hi_b && lo_b));

  assert_tristate_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_en_n |=> all_off);

  assert_powerdown_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up_n |=> all_off);

  assert_fault_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> all_off);

  assert_dead_gap_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_a) || $rose(lo_a)) |-> (off_run_a >= OSAT));

  assert_dead_gap_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_b) || $rose(lo_b)) |-> (off_run_b >= OSAT));
endmodule

bind bridge_gate_ctrl bgc_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tri_en_n (tri_en_n),
  .pwr_up_n (pwr_up_n),
  .fault    (fault),
  .hi_a     (hi_a),
  .lo_a     (lo_a),
  .hi_b     (hi_b),
  .lo_b     (lo_b)
);

// File: tb/bridge_gate_ctrl_tb.sv
`timescale 1ns/1ps
module bridge_gate_ctrl_tb;
  localparam int DEAD = 3;
  localparam int MINON = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_a = 1'b0, req_b = 1'b0;
  logic tri_en_n = 1'b1, pwr_up_n = 1'b1, fault = 1'b0;
  logic hi_a, lo_a, hi_b, lo_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  bridge_gate_ctrl #(.DEAD_CYC(DEAD), .MIN_ON_CYC(MINON)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
    .tri_en_n(tri_en_n), .pwr_up_n(pwr_up_n), .fault(fault),
    .hi_a(hi_a), .lo_a(lo_a), .hi_b(hi_b), .lo_b(lo_b)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {hi_a,lo_a,hi_b,lo_b} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] outs();
    return {hi_a, lo_a, hi_b, lo_b};
  endfunction

  // Reference model, written from the requirements: 0 off, 1 high, 2 low.
  int m_st[2], m_on[2], m_off[2];

  function automatic int desired(input bit ok, input bit r);
    if (!ok) return 0;
    return r ? 1 : 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_st[i] = 0; m_on[i] = 0; m_off[i] = 1;
      end
    end else begin
      bit ok;
      ok = tri_en_n && pwr_up_n && !fault;
      for (int i = 0; i < 2; i++) begin
        int w;
        w = desired(ok, (i == 0) ? req_a : req_b);
        if (m_st[i] == 0) begin
          if (w != 0 && m_off[i] >= DEAD) begin
            m_st[i] = w; m_on[i] = 1;
          end else if (m_off[i] < DEAD) begin
            m_off[i]++;
          end
        end else if (!ok || (w != m_st[i] && m_on[i] >= MINON)) begin
          m_st[i] = 0; m_off[i] = 1;
        end else if (m_on[i] < MINON) begin
          m_on[i]++;
        end
      end
    end
  end

  function automatic logic [3:0] model_outs();
    return {m_st[0] == 1, m_st[0] == 2, m_st[1] == 1, m_st[1] == 2};
  endfunction

  // Per-cycle comparison against the model (R9) and the overlap rule (R7).
  always @(negedge clk) begin
    if (model_on && !done) begin
      check("R9 model", outs(), model_outs());
      check("R7 overlap", {hi_a && lo_a, 1'b0, hi_b && lo_b, 1'b0}, 4'b0000);
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    settle(2);
    check("R1 in reset", outs(), 4'b0000);
    @(negedge clk) rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    check("R1 after release", outs(), 4'b0000);

    // R5 steady modes
    req_a = 0; req_b = 0; settle(DEAD + MINON + 4);
    check("R5 dump 00", outs(), 4'b0101);
    req_a = 1; req_b = 0; settle(DEAD + MINON + 4);
    check("R5 positive 10", outs(), 4'b1001);
    req_a = 0; req_b = 1; settle(DEAD + MINON + 4);
    check("R5 negative 01", outs(), 4'b0110);
    req_a = 1; req_b = 1; settle(DEAD + MINON + 4);
    check("R5 both high 11", outs(), 4'b1010);

    // R2, R3 and R4: forced off after one edge
    tri_en_n = 0; @(negedge clk);
    check("R2 tri-state", outs(), 4'b0000);
    settle(3); check("R2 tri-state held", outs(), 4'b0000);
    tri_en_n = 1; settle(DEAD + MINON + 4);
    pwr_up_n = 0; @(negedge clk);
    check("R3 power-down", outs(), 4'b0000);
    pwr_up_n = 1; settle(DEAD + MINON + 4);
    fault = 1; tri_en_n = 1; pwr_up_n = 1; @(negedge clk);
    check("R4 fault override", outs(), 4'b0000);
    fault = 0; settle(DEAD + MINON + 4);

    // R6 dead gap measured on leg A: high to low
    begin
      int gap;
      req_a = 0; gap = 0;
      @(negedge clk);
      while (!hi_a && !lo_a && gap < 50) begin gap++; @(negedge clk); end
      check("R6 dead gap", 4'(gap), 4'(DEAD));
      check("R6 low side after gap", {hi_a, lo_a, 2'b00}, 4'b0100);
    end
    settle(MINON + 2);

    // R8 short request stretched to the minimum on-time
    begin
      int width;
      req_a = 1;
      settle(DEAD + 1);
      req_a = 0; width = 0;
      while (hi_a && width < 50) begin width++; @(negedge clk); end
      check("R8 min on width", 4'(width), 4'(MINON));
    end
    settle(DEAD + MINON + 4);

    // Random phase, checked every cycle by the model (R2-R9)
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if ($urandom % 6 == 0) req_a = ~req_a;
      if ($urandom % 7 == 0) req_b = ~req_b;
      tri_en_n = ($urandom % 40) != 0;
      pwr_up_n = ($urandom % 55) != 0;
      fault    = ($urandom % 70) == 0;
    end
    @(negedge clk);
    finish_run();
  end
endmodule